// File: doc/BRIEF.md
# Owner-Tracking Coherence Directory Engine

This block keeps a set of private caches coherent over a shared group of memory blocks. The directory holds no sharer list. For each block it records only whether the block is owned and, if so, which cache owns it. The owning cache keeps the presence vector, one bit per cache, and only the owner's copy of that vector has meaning. Ownership and the presence vector move together from one cache to another whenever a cache that does not own a block writes to it.

Each cache raises a request naming a block and whether it reads or writes. The request stays high until the engine answers with a one-cycle done pulse for that cache. The engine serves one request at a time. Internally it runs a sequence of messages between the directory and the per-cache line controllers: directory fill, forward to owner, peer fill, redirect, vector transfer, owner notification, invalidate and write grant. The directory changes its owner field only when the new owner's notification arrives, so any request that arrives between a redirect and that notification waits.

The flattened line state and directory state are brought out as ports so that the owner of each block can be read directly.

Top module: `own_dir_coherence`

## Requirements
- R1: After reset, every line is invalid with write-enable, owner flag and presence vector all zero. Every block is unowned and done_o is zero.
- R2: A read miss to an unowned block leaves the requester valid and owner, with write-enable clear and a presence vector holding only its own bit (bit k means cache k). The directory then names the requester as owner.
- R3: A read miss to an owned block clears the owner's write-enable and sets the requester's bit in the owner's presence vector. The requester becomes valid with write-enable and owner flag clear, and the directory owner does not change.
- R4: A read to a valid line completes without changing any line or directory state.
- R5: A write to a line whose write-enable is set completes without changing any state.
- R6: An owner that writes without write-enable invalidates every other cache in its presence vector. Invalidated lines have valid, write-enable, owner flag and presence vector cleared. The owner then sets write-enable and reduces its presence vector to its own bit.
- R7: A write by a valid non-owner moves the owner flag and the old presence vector to the requester and points the directory at the requester. It then completes as in R6, so the old owner and all other sharers end invalid.
- R8: A write to an invalid line runs as a read miss (R2 or R3) followed by a write hit (R6 or R7). The requester ends as the only valid copy, as owner, with write-enable set.
- R9: Every block held by at least one cache has exactly one owner at every cycle. Write-enable is set only in a valid owning line. A block is marked owned in the directory exactly when some cache holds it.
- R10: One request is served at a time. Among simultaneous requests the lowest cache index goes first, and the others wait with their requests held. done_o is one-hot or zero and pulses only for a cache whose request is high.
- R11: The flattened outputs follow fixed layouts. Line state for cache c and block b sits at index c*N_BLOCKS+b, its presence vector at bits (c*N_BLOCKS+b)*N_CACHES and up, and the directory owner of block b at bits b*clog2(N_CACHES) and up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CACHES | Request held high per cache until done |
| req_wr_i | input | N_CACHES | 1 = write, 0 = read, per cache |
| req_blk_i | input | N_CACHES*clog2(N_BLOCKS) | Block index per cache |
| done_o | output | N_CACHES | One-cycle completion pulse per cache |
| line_v_o | output | N_CACHES*N_BLOCKS | Line valid flags |
| line_we_o | output | N_CACHES*N_BLOCKS | Line write-enable flags |
| line_own_o | output | N_CACHES*N_BLOCKS | Line owner flags |
| line_pres_o | output | N_CACHES*N_BLOCKS*N_CACHES | Presence vectors |
| dir_owned_o | output | N_BLOCKS | Directory owned flag per block |
| dir_owner_o | output | N_BLOCKS*clog2(N_CACHES) | Directory owner id per block |

## Verification
The bench builds the block with four caches and four blocks. Four caches allow an owner's presence vector to hold several sharers at once, so an ownership transfer carries a vector with more than one bit set and one write invalidates several lines. Four blocks keep per-block state separate, so write misses to unowned and owned blocks and two same-cycle requests can each run on a fresh block while the lines of earlier blocks are checked to stay unchanged.

// File: rtl/own_dir_pkg.sv
package own_dir_pkg;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_FILL_DIR, CMD_FWD, CMD_FILL_PEER, CMD_XFER, CMD_INV, CMD_GRANT
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOOK, ST_FILL_DIR, ST_FWD, ST_FILL_PEER,
    ST_REDIR, ST_XFER, ST_NOTIFY, ST_INV, ST_GRANT, ST_DONE
  } st_e;
endpackage

// File: rtl/od_prio_pick.sv
module od_prio_pick #(
  parameter int unsigned N_REQ = 4
) (
  input  logic [N_REQ-1:0]         req_i,
  output logic                     any_o,
  output logic [$clog2(N_REQ)-1:0] id_o
);
  localparam int unsigned IDW = $clog2(N_REQ);

  always_comb begin
    id_o = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = IDW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/od_cache_ctrl.sv
module od_cache_ctrl
  import own_dir_pkg::*;
#(
  parameter int unsigned N_CACHES = 4,
  parameter int unsigned N_BLOCKS = 4,
  parameter int unsigned CACHE_ID = 0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  cmd_e                        cmd_i,
  input  logic [$clog2(N_BLOCKS)-1:0] cmd_blk_i,
  input  logic [$clog2(N_CACHES)-1:0] cmd_req_i,
  input  logic [$clog2(N_CACHES)-1:0] cmd_own_i,
  input  logic [N_CACHES-1:0]         cmd_vec_i,
  output logic [N_BLOCKS-1:0]         v_o,
  output logic [N_BLOCKS-1:0]         we_o,
  output logic [N_BLOCKS-1:0]         own_o,
  output logic [N_BLOCKS*N_CACHES-1:0] pres_o
);
  localparam int unsigned IDW = $clog2(N_CACHES);
  localparam int unsigned BW  = $clog2(N_BLOCKS);
  localparam logic [IDW-1:0] MY_ID = IDW'(CACHE_ID);
  localparam logic [N_CACHES-1:0] MY_BIT = N_CACHES'(1) << CACHE_ID;

  logic is_req, is_own;
  logic [N_CACHES-1:0] req_bit;
  assign is_req  = (cmd_req_i == MY_ID);
  assign is_own  = (cmd_own_i == MY_ID);
  assign req_bit = N_CACHES'(1) << cmd_req_i;

  for (genvar b = 0; b < N_BLOCKS; b++) begin : g_line
    logic v_q, we_q, own_q;
    logic [N_CACHES-1:0] pres_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0; we_q <= 1'b0; own_q <= 1'b0; pres_q <= '0;
      end else if (cmd_blk_i == BW'(b)) begin
        unique case (cmd_i)
          CMD_FILL_DIR: if (is_req) begin
            v_q <= 1'b1; we_q <= 1'b0; own_q <= 1'b1; pres_q <= MY_BIT;
          end
          CMD_FWD: if (is_own) begin
            we_q <= 1'b0; pres_q <= pres_q | req_bit;
          end
          CMD_FILL_PEER: if (is_req) begin
            v_q <= 1'b1; we_q <= 1'b0; own_q <= 1'b0;
          end
          CMD_XFER: begin
            // old owner hands off in the same cycle the requester takes over
            if (is_req) begin
              own_q <= 1'b1; pres_q <= cmd_vec_i;
            end else if (is_own) begin
              own_q <= 1'b0; pres_q <= '0;
            end
          end
          CMD_INV: if (cmd_vec_i[CACHE_ID]) begin
            v_q <= 1'b0; we_q <= 1'b0; own_q <= 1'b0; pres_q <= '0;
          end
          CMD_GRANT: if (is_req) begin
            we_q <= 1'b1; pres_q <= MY_BIT;
          end
          default: ;
        endcase
      end
    end

    assign v_o[b]   = v_q;
    assign we_o[b]  = we_q;
    assign own_o[b] = own_q;
    assign pres_o[b*N_CACHES +: N_CACHES] = pres_q;
  end
endmodule

// File: rtl/od_dir_ctrl.sv
module od_dir_ctrl
  import own_dir_pkg::*;
#(
  parameter int unsigned N_CACHES = 4,
  parameter int unsigned N_BLOCKS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          pick_any_i,
  input  logic [$clog2(N_CACHES)-1:0]   pick_id_i,
  input  logic [$clog2(N_BLOCKS)-1:0]   pick_blk_i,
  input  logic                          pick_wr_i,
  input  logic                          rq_v_i,
  input  logic                          rq_we_i,
  input  logic                          rq_own_i,
  input  logic [N_CACHES-1:0]           rq_pres_i,
  input  logic [N_CACHES-1:0]           ow_pres_i,
  output cmd_e                          cmd_o,
  output logic [$clog2(N_BLOCKS)-1:0]   cmd_blk_o,
  output logic [$clog2(N_CACHES)-1:0]   cmd_req_o,
  output logic [$clog2(N_CACHES)-1:0]   cmd_own_o,
  output logic [N_CACHES-1:0]           cmd_vec_o,
  output logic [N_CACHES-1:0]           done_o,
  output logic [N_BLOCKS-1:0]           owned_o,
  output logic [N_BLOCKS*$clog2(N_CACHES)-1:0] owner_o
);
  localparam int unsigned IDW = $clog2(N_CACHES);
  localparam int unsigned BW  = $clog2(N_BLOCKS);

  st_e st_q;
  logic [IDW-1:0] req_q;
  logic [BW-1:0]  blk_q;
  logic           wr_q;
  logic [N_CACHES-1:0] vec_q;
  logic [N_BLOCKS-1:0] owned_q;
  logic [IDW-1:0] owner_q [N_BLOCKS];
  logic [N_CACHES-1:0] req_bit;

  assign req_bit = N_CACHES'(1) << req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; req_q <= '0; blk_q <= '0; wr_q <= 1'b0; vec_q <= '0;
      owned_q <= '0;
      for (int b = 0; b < N_BLOCKS; b++) owner_q[b] <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (pick_any_i) begin
          req_q <= pick_id_i; blk_q <= pick_blk_i; wr_q <= pick_wr_i;
          st_q  <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!rq_v_i)            st_q <= owned_q[blk_q] ? ST_FWD : ST_FILL_DIR;
          else if (!wr_q || rq_we_i) st_q <= ST_DONE;
          else if (rq_own_i) begin
            vec_q <= rq_pres_i & ~req_bit;
            st_q  <= ST_INV;
          end else                st_q <= ST_REDIR;
        end
        ST_FILL_DIR: begin
          owned_q[blk_q] <= 1'b1;
          owner_q[blk_q] <= req_q;
          st_q <= ST_LOOK;
        end
        ST_FWD:       st_q <= ST_FILL_PEER;
        ST_FILL_PEER: st_q <= ST_LOOK;
        ST_REDIR: begin
          vec_q <= ow_pres_i;
          st_q  <= ST_XFER;
        end
        ST_XFER:      st_q <= ST_NOTIFY;
        ST_NOTIFY: begin
          // owner field moves only on the new owner's notification
          owner_q[blk_q] <= req_q;
          st_q <= ST_LOOK;
        end
        ST_INV:   st_q <= ST_GRANT;
        ST_GRANT: st_q <= ST_DONE;
        ST_DONE:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_FILL_DIR:  cmd_o = CMD_FILL_DIR;
      ST_FWD:       cmd_o = CMD_FWD;
      ST_FILL_PEER: cmd_o = CMD_FILL_PEER;
      ST_XFER:      cmd_o = CMD_XFER;
      ST_INV:       cmd_o = CMD_INV;
      ST_GRANT:     cmd_o = CMD_GRANT;
      default:      cmd_o = CMD_NONE;
    endcase
  end

  assign cmd_blk_o = blk_q;
  assign cmd_req_o = req_q;
  assign cmd_own_o = owner_q[blk_q];
  assign cmd_vec_o = vec_q;
  assign done_o    = (st_q == ST_DONE) ? req_bit : '0;
  assign owned_o   = owned_q;
  for (genvar b = 0; b < N_BLOCKS; b++) begin : g_own
    assign owner_o[b*IDW +: IDW] = owner_q[b];
  end
endmodule

// File: rtl/own_dir_coherence.sv
module own_dir_coherence
  import own_dir_pkg::*;
#(
  parameter int unsigned N_CACHES = 4,
  parameter int unsigned N_BLOCKS = 4
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [N_CACHES-1:0]                    req_i,
  input  logic [N_CACHES-1:0]                    req_wr_i,
  input  logic [N_CACHES*$clog2(N_BLOCKS)-1:0]   req_blk_i,
  output logic [N_CACHES-1:0]                    done_o,
  output logic [N_CACHES*N_BLOCKS-1:0]           line_v_o,
  output logic [N_CACHES*N_BLOCKS-1:0]           line_we_o,
  output logic [N_CACHES*N_BLOCKS-1:0]           line_own_o,
  output logic [N_CACHES*N_BLOCKS*N_CACHES-1:0]  line_pres_o,
  output logic [N_BLOCKS-1:0]                    dir_owned_o,
  output logic [N_BLOCKS*$clog2(N_CACHES)-1:0]   dir_owner_o
);
  localparam int unsigned IDW = $clog2(N_CACHES);
  localparam int unsigned BW  = $clog2(N_BLOCKS);
  localparam int unsigned PW  = N_BLOCKS * N_CACHES;

  logic           pick_any;
  logic [IDW-1:0] pick_id;
  cmd_e           cmd;
  logic [BW-1:0]  cmd_blk;
  logic [IDW-1:0] cmd_req, cmd_own;
  logic [N_CACHES-1:0] cmd_vec;

  logic [N_BLOCKS-1:0] c_v   [N_CACHES];
  logic [N_BLOCKS-1:0] c_we  [N_CACHES];
  logic [N_BLOCKS-1:0] c_own [N_CACHES];
  logic [PW-1:0]       c_pres[N_CACHES];

  od_prio_pick #(.N_REQ(N_CACHES)) u_pick (
    .req_i(req_i), .any_o(pick_any), .id_o(pick_id)
  );

  od_dir_ctrl #(.N_CACHES(N_CACHES), .N_BLOCKS(N_BLOCKS)) u_dir (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pick_any_i(pick_any), .pick_id_i(pick_id),
    .pick_blk_i(req_blk_i[pick_id*BW +: BW]), .pick_wr_i(req_wr_i[pick_id]),
    .rq_v_i(c_v[cmd_req][cmd_blk]), .rq_we_i(c_we[cmd_req][cmd_blk]),
    .rq_own_i(c_own[cmd_req][cmd_blk]),
    .rq_pres_i(c_pres[cmd_req][cmd_blk*N_CACHES +: N_CACHES]),
    .ow_pres_i(c_pres[cmd_own][cmd_blk*N_CACHES +: N_CACHES]),
    .cmd_o(cmd), .cmd_blk_o(cmd_blk), .cmd_req_o(cmd_req), .cmd_own_o(cmd_own),
    .cmd_vec_o(cmd_vec), .done_o(done_o),
    .owned_o(dir_owned_o), .owner_o(dir_owner_o)
  );

  for (genvar c = 0; c < N_CACHES; c++) begin : g_cache
    od_cache_ctrl #(.N_CACHES(N_CACHES), .N_BLOCKS(N_BLOCKS), .CACHE_ID(c)) u_line (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .cmd_i(cmd), .cmd_blk_i(cmd_blk), .cmd_req_i(cmd_req), .cmd_own_i(cmd_own),
      .cmd_vec_i(cmd_vec),
      .v_o(c_v[c]), .we_o(c_we[c]), .own_o(c_own[c]), .pres_o(c_pres[c])
    );
    assign line_v_o  [c*N_BLOCKS +: N_BLOCKS] = c_v[c];
    assign line_we_o [c*N_BLOCKS +: N_BLOCKS] = c_we[c];
    assign line_own_o[c*N_BLOCKS +: N_BLOCKS] = c_own[c];
    assign line_pres_o[c*PW +: PW]            = c_pres[c];
  end
endmodule

// File: rtl/own_dir_chk.sv
module own_dir_chk #(
  parameter int unsigned N_CACHES = 4,
  parameter int unsigned N_BLOCKS = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [N_CACHES-1:0]          req_i,
  input logic [N_CACHES-1:0]          done_o,
  input logic [N_CACHES*N_BLOCKS-1:0] line_v_o,
  input logic [N_CACHES*N_BLOCKS-1:0] line_we_o,
  input logic [N_CACHES*N_BLOCKS-1:0] line_own_o,
  input logic [N_BLOCKS-1:0]          dir_owned_o
);
  // R10
  done_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));
  // R10
  done_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o & ~req_i) == '0);

  for (genvar b = 0; b < N_BLOCKS; b++) begin : g_blk
    logic [N_CACHES-1:0] v_b, own_b;
    for (genvar c = 0; c < N_CACHES; c++) begin : g_c
      assign v_b[c]   = line_v_o[c*N_BLOCKS+b];
      assign own_b[c] = line_own_o[c*N_BLOCKS+b];
      // R9
      we_needs_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_we_o[c*N_BLOCKS+b] |-> (line_own_o[c*N_BLOCKS+b] && line_v_o[c*N_BLOCKS+b]));
    end
    // R9
    one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|v_b) |-> ($countones(own_b) == 1));
    // R9
    owner_is_holder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own_b & ~v_b) == '0);
    // R9
    dir_owned_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dir_owned_o[b] == (|v_b));
  end
endmodule

bind own_dir_coherence own_dir_chk #(.N_CACHES(N_CACHES), .N_BLOCKS(N_BLOCKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .done_o(done_o),
  .line_v_o(line_v_o), .line_we_o(line_we_o), .line_own_o(line_own_o),
  .dir_owned_o(dir_owned_o)
);

// File: tb/own_dir_coherence_tb.sv
module own_dir_coherence_tb;
  localparam int N   = 4;
  localparam int NB  = 4;
  localparam int IDW = $clog2(N);
  localparam int BW  = $clog2(NB);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] req_i = '0, req_wr_i = '0;
  logic [N*BW-1:0] req_blk_i = '0;
  logic [N-1:0] done_o;
  logic [N*NB-1:0] line_v_o, line_we_o, line_own_o;
  logic [N*NB*N-1:0] line_pres_o;
  logic [NB-1:0] dir_owned_o;
  logic [NB*IDW-1:0] dir_owner_o;

  always #2 clk_i = ~clk_i;

  own_dir_coherence #(.N_CACHES(N), .N_BLOCKS(NB)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_wr_i(req_wr_i),
    .req_blk_i(req_blk_i), .done_o(done_o), .line_v_o(line_v_o),
    .line_we_o(line_we_o), .line_own_o(line_own_o), .line_pres_o(line_pres_o),
    .dir_owned_o(dir_owned_o), .dir_owner_o(dir_owner_o)
  );

  typedef struct packed {
    logic [IDW-1:0]    who;
    logic [N*NB-1:0]   v, we, own;
    logic [N*NB*N-1:0] pres;
    logic [NB-1:0]     downed;
    logic [NB*IDW-1:0] down;
  } snap_t;

  int checks = 0, errors = 0;
  snap_t exp_q[$];
  string tag_q[$];

  logic [N*NB-1:0]   m_v = '0, m_we = '0, m_own = '0;
  logic [N*NB*N-1:0] m_pres = '0;
  logic [NB-1:0]     m_downed = '0;
  logic [NB*IDW-1:0] m_down = '0;

  function automatic snap_t snap(int c);
    snap_t s;
    s.who = IDW'(c); s.v = m_v; s.we = m_we; s.own = m_own; s.pres = m_pres;
    s.downed = m_downed; s.down = m_down;
    return s;
  endfunction

  task automatic model_apply(int c, int b, bit wr);
    int i, o;
    logic [N-1:0] vec;
    i = c*NB + b;
    if (!m_v[i]) begin
      if (!m_downed[b]) begin
        m_v[i] = 1'b1; m_own[i] = 1'b1; m_we[i] = 1'b0;
        m_pres[i*N +: N] = N'(1) << c;
        m_downed[b] = 1'b1; m_down[b*IDW +: IDW] = IDW'(c);
      end else begin
        o = int'(m_down[b*IDW +: IDW]);
        m_we[o*NB+b] = 1'b0;
        m_pres[(o*NB+b)*N + c] = 1'b1;
        m_v[i] = 1'b1; m_we[i] = 1'b0; m_own[i] = 1'b0;
      end
    end
    if (wr && !m_we[i]) begin
      if (!m_own[i]) begin
        o = int'(m_down[b*IDW +: IDW]);
        vec = m_pres[(o*NB+b)*N +: N];
        m_own[o*NB+b] = 1'b0; m_pres[(o*NB+b)*N +: N] = '0;
        m_own[i] = 1'b1; m_pres[i*N +: N] = vec;
        m_down[b*IDW +: IDW] = IDW'(c);
      end
      vec = m_pres[i*N +: N];
      for (int k = 0; k < N; k++) begin
        if (k != c && vec[k]) begin
          m_v[k*NB+b] = 1'b0; m_we[k*NB+b] = 1'b0; m_own[k*NB+b] = 1'b0;
          m_pres[(k*NB+b)*N +: N] = '0;
        end
      end
      m_we[i] = 1'b1; m_pres[i*N +: N] = N'(1) << c;
    end
  endtask

  task automatic check_state(snap_t e, string tag);
    checks++;
    if (line_v_o !== e.v || line_we_o !== e.we || line_own_o !== e.own ||
        line_pres_o !== e.pres || dir_owned_o !== e.downed || dir_owner_o !== e.down) begin
      errors++;
      $display("FAIL %s state: v=%h we=%h own=%h pres=%h owned=%h owner=%h expected v=%h we=%h own=%h pres=%h owned=%h owner=%h",
        tag, line_v_o, line_we_o, line_own_o, line_pres_o, dir_owned_o, dir_owner_o,
        e.v, e.we, e.own, e.pres, e.downed, e.down);
    end
  endtask

  // monitor: pops the expected item when a completion appears
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && done_o != '0) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected done: actual %b expected none", done_o);
        end else begin
          snap_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (done_o !== (N'(1) << e.who)) begin
            errors++;
            $display("FAIL %s done: actual %b expected %b", t, done_o, N'(1) << e.who);
          end
          check_state(e, t);
        end
      end
    end
  end

  task automatic push_exp(int c, int b, bit wr, string tag);
    model_apply(c, b, wr);
    exp_q.push_back(snap(c));
    tag_q.push_back(tag);
  endtask

  task automatic wait_done(int c);
    do @(negedge clk_i); while (!done_o[c]);
    @(negedge clk_i);
    req_i[c] = 1'b0;
  endtask

  task automatic do_op(int c, int b, bit wr, string tag);
    @(negedge clk_i);
    push_exp(c, b, wr, tag);
    req_blk_i[c*BW +: BW] = BW'(b);
    req_wr_i[c] = wr;
    req_i[c] = 1'b1;
    wait_done(c);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state, R11 layout
    check_state(snap(0), "R1");
    checks++;
    if (done_o !== '0) begin
      errors++;
      $display("FAIL R1 done: actual %b expected 0", done_o);
    end

    do_op(0, 0, 1'b0, "R2 unowned read miss");
    do_op(1, 0, 1'b0, "R3 owned read miss c1");
    do_op(2, 0, 1'b0, "R3 owned read miss c2");
    do_op(1, 0, 1'b0, "R4 read hit");
    do_op(1, 0, 1'b1, "R7 non-owner write");
    do_op(1, 0, 1'b1, "R5 write with we");
    do_op(3, 0, 1'b0, "R3 read clears owner we");
    do_op(1, 0, 1'b1, "R6 owner write invalidates");
    do_op(2, 1, 1'b1, "R8 write miss unowned");
    do_op(0, 1, 1'b1, "R8 write miss owned");
    do_op(0, 3, 1'b0, "R2 second block");
    do_op(2, 3, 1'b0, "R3 second block");
    do_op(0, 3, 1'b1, "R6 owner write with sharer");

    // R10 simultaneous requests: lower index first, other waits
    @(negedge clk_i);
    push_exp(1, 2, 1'b0, "R10 first served c1");
    push_exp(3, 2, 1'b0, "R10 second served c3");
    req_blk_i[1*BW +: BW] = BW'(2); req_wr_i[1] = 1'b0;
    req_blk_i[3*BW +: BW] = BW'(2); req_wr_i[3] = 1'b0;
    req_i[1] = 1'b1; req_i[3] = 1'b1;
    wait_done(1);
    wait_done(3);

    do_op(3, 2, 1'b1, "R7 transfer after concurrent");

    repeat (4) @(negedge clk_i);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending completions: actual %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule